// File: doc/BRIEF.md
# Six-Channel DMA Control Hub

This block is the shared front end of a six-channel DMA controller. It decodes a flat word-addressed register space into one register bank per channel, placed at a fixed 32-byte stride, and into a small group of global registers at the top of the space. It holds the controller-wide run state: an enable flag, a halt flag, a sticky address-error flag and a two-bit arbitration mode. Every register write is bit-masked, so software can change a few bits without a read-modify-write.

The hub also collects per-channel completion into one interrupt summary word and a single interrupt line. It picks which requesting channel owns the shared memory port in each cycle. The channels that move data sit outside this block. They raise a request, report completion with a one-cycle done pulse and report a bad address with a one-cycle error pulse. An address error from any channel stops the whole controller until software restarts it.

Top module: `dma_ctl_hub`

## Requirements
- R1: Channel n (0..5) owns seven 32-bit read/write registers at byte offsets n*0x20 + 4*k for k = 0..6 (source, destination, count, request type, status/control, command, descriptor). Each one reads back what was written and no other register changes. All registers reset to zero.
- R2: The global control word at 0x300 keeps only bit 0 (enable), bit 2 (address error), bit 3 (halt) and bits 9:8 (arbitration mode). Every other bit reads zero, and the word resets to zero.
- R3: A write changes only the register bits whose `bus_wmask` bit is 1. Those bits take the `bus_wdata` value and all other bits keep their old value.
- R4: Offsets outside the map read as zero and writes to them change nothing. This covers slot +0x1C of each channel, 0xC0 to 0x2FF, addresses above 0x30C and addresses that are not word-aligned.
- R5: Channel i is granted only while `ch_req[i]` is 1, status bit 0 of channel i is 1, global enable is 1 and global halt is 0. At most one grant bit is high, and the grant is combinational from the current state.
- R6: With arbitration mode 0, the lowest-numbered eligible channel is granted.
- R7: With any non-zero arbitration mode, the search starts at the channel after the one granted last (in any mode) and wraps around. After reset, channel 0 is searched first.
- R8: A `ch_done_set[i]` pulse sets status bit 3 of channel i at the next edge. If a software write clears that bit in the same cycle, the pulse wins. Bit i of the interrupt summary at 0x304 (read-only) is status bit 3 AND command bit 1 of channel i, and `irq_out` is the OR of the summary bits.
- R9: When software clears status bit 3 of channel i, summary bit i and, if no other bit is set, `irq_out` drop right after the write.
- R10: A `ch_addr_err[i]` pulse sets status bit 4 of channel i and global bits 2 and 3 at the next edge, which blocks every grant.
- R11: A write to 0x30C sets the doorbell bits selected by the low six bits of wdata AND wmask. A write to 0x308 clears the bits selected the same way. 0x308 reads the six doorbell bits, and higher bits are neither stored nor read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe, sampled on the rising edge |
| bus_addr | input | 10 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_wmask | input | 32 | Per-bit write enable |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| ch_req | input | 6 | Memory-port request from each channel |
| ch_done_set | input | 6 | One-cycle transfer-done pulse per channel |
| ch_addr_err | input | 6 | One-cycle address-error pulse per channel |
| port_grant | output | 6 | One-hot memory-port grant |
| irq_out | output | 1 | Combined interrupt line |

## Verification
Fixed-priority arbitration is driven from a table of request patterns: the empty pattern, a single request, all requests, and sparse patterns whose lowest bit differs from their highest bit. A wrong scan direction or a wrong bit order therefore shows up as a different grant. Round-robin is tried with a continuous all-request stream, which separates rotation from fixed priority, and with sparse two-channel and single-channel streams, which check that idle channels are skipped and that the pointer wraps. Register tests use partial masks, so a masked write can be told apart from a full-word write. They use distinct values in distant channel slots, which separates correct stride decoding from aliasing. A done pulse that collides with a software clear shows which of the two has precedence.

// File: rtl/dma_hub_pkg.sv
package dma_hub_pkg;
   // channel window: 2**CH_SPAN_LG2 bytes per channel
   localparam int CH_SPAN_LG2   = 5;
   localparam int REGS_PER_CH   = 7;
   localparam int REG_IDX_W     = CH_SPAN_LG2 - 2;

   // register index inside a channel window
   localparam int RI_SRC  = 0;
   localparam int RI_DST  = 1;
   localparam int RI_CNT  = 2;
   localparam int RI_RTYP = 3;
   localparam int RI_STAT = 4;
   localparam int RI_CMD  = 5;
   localparam int RI_DESC = 6;

   // global register offsets
   localparam int GLB_CTRL_OFS  = 'h300;
   localparam int GLB_IRQ_OFS   = 'h304;
   localparam int GLB_DBCLR_OFS = 'h308;
   localparam int GLB_DBSET_OFS = 'h30C;

   // status/control bits of a channel
   localparam int ST_RUN  = 0;
   localparam int ST_DONE = 3;
   localparam int ST_AERR = 4;
   // command bits of a channel
   localparam int CM_IRQ  = 1;
   // global control bits
   localparam int GC_EN    = 0;
   localparam int GC_AERR  = 2;
   localparam int GC_HALT  = 3;
   localparam int GC_MODE  = 8;
   localparam int GC_KEEP  = 'h30D;

   function automatic logic [31:0] masked_merge(input logic [31:0] old_v,
                                                 input logic [31:0] new_v,
                                                 input logic [31:0] msk);
      return (old_v & ~msk) | (new_v & msk);
   endfunction
endpackage

// File: rtl/dma_hub_decode.sv
module dma_hub_decode
   import dma_hub_pkg::*;
#(
   parameter int NUM_CH = 6,
   parameter int ADDR_W = 10
) (
   input  logic [ADDR_W-1:0]    addr,
   output logic [NUM_CH-1:0]    ch_sel,
   output logic [REG_IDX_W-1:0] reg_idx,
   output logic                 ctrl_sel,
   output logic                 irqs_sel,
   output logic                 dbclr_sel,
   output logic                 dbset_sel
);
   localparam int FIELD_W = ADDR_W - CH_SPAN_LG2;

   logic               aligned;
   logic [FIELD_W-1:0] ch_field;
   logic               slot_ok;

   assign aligned  = (addr[1:0] == 2'b00);
   assign ch_field = addr[ADDR_W-1:CH_SPAN_LG2];
   assign reg_idx  = addr[CH_SPAN_LG2-1:2];
   assign slot_ok  = aligned && (int'(reg_idx) < REGS_PER_CH);

   for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
      assign ch_sel[g] = slot_ok && (ch_field == FIELD_W'(g));
   end

   assign ctrl_sel  = (addr == ADDR_W'(GLB_CTRL_OFS));
   assign irqs_sel  = (addr == ADDR_W'(GLB_IRQ_OFS));
   assign dbclr_sel = (addr == ADDR_W'(GLB_DBCLR_OFS));
   assign dbset_sel = (addr == ADDR_W'(GLB_DBSET_OFS));
endmodule

// File: rtl/dma_hub_chan_bank.sv
module dma_hub_chan_bank
   import dma_hub_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [REG_IDX_W-1:0] reg_idx,
   input  logic [DATA_W-1:0]    wdata,
   input  logic [DATA_W-1:0]    wmask,
   input  logic                 done_set,
   input  logic                 aerr_set,
   output logic [DATA_W-1:0]    rdata,
   output logic                 chan_run,
   output logic                 xfer_done,
   output logic                 irq_en
);
   logic [DATA_W-1:0] regs_q [REGS_PER_CH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < REGS_PER_CH; k++) regs_q[k] <= '0;
      end else begin
         for (int k = 0; k < REGS_PER_CH; k++) begin
            if (wr_en && (int'(reg_idx) == k))
               regs_q[k] <= (regs_q[k] & ~wmask) | (wdata & wmask);
         end
         // hardware events take precedence over a same-cycle software write
         if (done_set) regs_q[RI_STAT][ST_DONE] <= 1'b1;
         if (aerr_set) regs_q[RI_STAT][ST_AERR] <= 1'b1;
      end
   end

   always_comb begin
      rdata = '0;
      for (int k = 0; k < REGS_PER_CH; k++)
         if (int'(reg_idx) == k) rdata = regs_q[k];
   end

   assign chan_run  = regs_q[RI_STAT][ST_RUN];
   assign xfer_done = regs_q[RI_STAT][ST_DONE];
   assign irq_en    = regs_q[RI_CMD][CM_IRQ];
endmodule

// File: rtl/dma_hub_glb.sv
module dma_hub_glb
   import dma_hub_pkg::*;
#(
   parameter int NUM_CH = 6,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic              dbclr_wr,
   input  logic              dbset_wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] wmask,
   input  logic              any_aerr,
   output logic [DATA_W-1:0] ctrl_rd,
   output logic [NUM_CH-1:0] db_rd,
   output logic              glb_en,
   output logic              glb_halt,
   output logic              glb_aerr,
   output logic [1:0]        glb_mode
);
   localparam logic [DATA_W-1:0] KEEP = DATA_W'(GC_KEEP);

   logic [DATA_W-1:0] ctrl_q;
   logic [NUM_CH-1:0] db_q;
   logic [NUM_CH-1:0] db_bits;

   assign db_bits = wdata[NUM_CH-1:0] & wmask[NUM_CH-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else begin
         if (ctrl_wr)
            ctrl_q <= ((ctrl_q & ~wmask) | (wdata & wmask)) & KEEP;
         if (any_aerr) begin
            ctrl_q[GC_AERR] <= 1'b1;
            ctrl_q[GC_HALT] <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        db_q <= '0;
      else if (dbset_wr) db_q <= db_q | db_bits;
      else if (dbclr_wr) db_q <= db_q & ~db_bits;
   end

   assign ctrl_rd  = ctrl_q;
   assign db_rd    = db_q;
   assign glb_en   = ctrl_q[GC_EN];
   assign glb_halt = ctrl_q[GC_HALT];
   assign glb_aerr = ctrl_q[GC_AERR];
   assign glb_mode = ctrl_q[GC_MODE+1:GC_MODE];
endmodule

// File: rtl/dma_hub_arb.sv
module dma_hub_arb #(
   parameter int NUM_CH    = 6,
   parameter bit RR_ENABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] elig,
   input  logic              rr_mode,
   output logic [NUM_CH-1:0] grant
);
   localparam int IDX_W = $clog2(NUM_CH);

   logic [IDX_W-1:0]  last_q;
   logic [IDX_W-1:0]  g_idx;
   logic [NUM_CH-1:0] fx_g;
   logic [NUM_CH-1:0] rr_g;

   // fixed priority: scan downwards so the lowest index is kept
   always_comb begin
      fx_g = '0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (elig[i]) begin
            fx_g    = '0;
            fx_g[i] = 1'b1;
         end
      end
   end

   if (RR_ENABLE) begin : g_rr
      always_comb begin
         logic found;
         int   idx;
         rr_g  = '0;
         found = 1'b0;
         for (int k = 1; k <= NUM_CH; k++) begin
            idx = (int'(last_q) + k) % NUM_CH;
            if (!found && elig[idx]) begin
               rr_g[idx] = 1'b1;
               found     = 1'b1;
            end
         end
      end
   end else begin : g_fixed_only
      assign rr_g = fx_g;
   end

   assign grant = rr_mode ? rr_g : fx_g;

   always_comb begin
      g_idx = last_q;
      for (int i = 0; i < NUM_CH; i++)
         if (grant[i]) g_idx = IDX_W'(i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      last_q <= IDX_W'(NUM_CH - 1);
      else if (|grant) last_q <= g_idx;
   end
endmodule

// File: rtl/dma_ctl_hub.sv
module dma_ctl_hub
   import dma_hub_pkg::*;
#(
   parameter int NUM_CH    = 6,
   parameter int ADDR_W    = 10,
   parameter int DATA_W    = 32,
   parameter bit RR_ENABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_wmask,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NUM_CH-1:0] ch_req,
   input  logic [NUM_CH-1:0] ch_done_set,
   input  logic [NUM_CH-1:0] ch_addr_err,
   output logic [NUM_CH-1:0] port_grant,
   output logic              irq_out
);
   // elaboration-time parameter checks
   if (NUM_CH < 2 || NUM_CH > 16)
      $error("dma_ctl_hub: NUM_CH must lie in 2..16");
   if ((NUM_CH << CH_SPAN_LG2) > GLB_CTRL_OFS)
      $error("dma_ctl_hub: channel windows overlap the global registers");
   if (ADDR_W < 10 || ADDR_W > 16)
      $error("dma_ctl_hub: ADDR_W must lie in 10..16");
   if (DATA_W != 32)
      $error("dma_ctl_hub: DATA_W must be 32");

   logic [NUM_CH-1:0]    ch_sel;
   logic [REG_IDX_W-1:0] reg_idx;
   logic                 ctrl_sel, irqs_sel, dbclr_sel, dbset_sel;
   logic [DATA_W-1:0]    bank_rd [NUM_CH];
   logic [NUM_CH-1:0]    ch_run_vec, ch_done_vec, ch_irqen_vec;
   logic [NUM_CH-1:0]    irq_stat, elig, db_rd;
   logic [DATA_W-1:0]    ctrl_rd;
   logic                 glb_en, glb_halt, glb_aerr;
   logic [1:0]           glb_mode;

   dma_hub_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
      .addr(bus_addr), .ch_sel(ch_sel), .reg_idx(reg_idx),
      .ctrl_sel(ctrl_sel), .irqs_sel(irqs_sel),
      .dbclr_sel(dbclr_sel), .dbset_sel(dbset_sel)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_bank
      dma_hub_chan_bank #(.DATA_W(DATA_W)) u_bank (
         .clk(clk), .rst_n(rst_n),
         .wr_en(bus_we & ch_sel[g]), .reg_idx(reg_idx),
         .wdata(bus_wdata), .wmask(bus_wmask),
         .done_set(ch_done_set[g]), .aerr_set(ch_addr_err[g]),
         .rdata(bank_rd[g]), .chan_run(ch_run_vec[g]),
         .xfer_done(ch_done_vec[g]), .irq_en(ch_irqen_vec[g])
      );
   end

   dma_hub_glb #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_glb (
      .clk(clk), .rst_n(rst_n),
      .ctrl_wr(bus_we & ctrl_sel), .dbclr_wr(bus_we & dbclr_sel),
      .dbset_wr(bus_we & dbset_sel),
      .wdata(bus_wdata), .wmask(bus_wmask), .any_aerr(|ch_addr_err),
      .ctrl_rd(ctrl_rd), .db_rd(db_rd),
      .glb_en(glb_en), .glb_halt(glb_halt), .glb_aerr(glb_aerr),
      .glb_mode(glb_mode)
   );

   assign elig = ch_req & ch_run_vec & {NUM_CH{glb_en & ~glb_halt}};

   dma_hub_arb #(.NUM_CH(NUM_CH), .RR_ENABLE(RR_ENABLE)) u_arb (
      .clk(clk), .rst_n(rst_n), .elig(elig),
      .rr_mode(glb_mode != 2'b00), .grant(port_grant)
   );

   assign irq_stat = ch_done_vec & ch_irqen_vec;
   assign irq_out  = |irq_stat;

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_CH; i++)
         if (ch_sel[i]) bus_rdata = bus_rdata | bank_rd[i];
      if (ctrl_sel)  bus_rdata = bus_rdata | ctrl_rd;
      if (irqs_sel)  bus_rdata = bus_rdata | DATA_W'(irq_stat);
      if (dbclr_sel) bus_rdata = bus_rdata | DATA_W'(db_rd);
   end
endmodule

// File: rtl/dma_hub_chk.sv
module dma_hub_chk #(
   parameter int NUM_CH = 6,
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [NUM_CH-1:0] ch_req,
   input logic [NUM_CH-1:0] ch_done_set,
   input logic [NUM_CH-1:0] ch_addr_err,
   input logic [NUM_CH-1:0] port_grant,
   input logic              irq_out,
   input logic [NUM_CH-1:0] ch_run_vec,
   input logic [NUM_CH-1:0] ch_irqen_vec,
   input logic              glb_en,
   input logic              glb_halt,
   input logic              glb_aerr,
   input logic [1:0]        glb_mode
);
   // R5: never more than one owner of the memory port
   a_r5_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(port_grant));

   // R5: no grant unless the controller runs
   a_r5_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (|port_grant) |-> (glb_en && !glb_halt));

   // R5: only a requesting, running channel may be granted
   a_r5_req_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (port_grant & ~(ch_req & ch_run_vec)) == '0);

   // R6: channel 0 always wins in fixed mode
   a_r6_ch0_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (glb_mode == 2'b00 && glb_en && !glb_halt && ch_req[0] && ch_run_vec[0])
      |-> port_grant[0]);

   // R7: rotation never grants the same channel twice in a row under contention
   a_r7_rotates: assert property (@(posedge clk) disable iff (!rst_n)
      (glb_mode != 2'b00 && glb_en && !glb_halt &&
       $countones(ch_req & ch_run_vec) > 1)
      |-> ((port_grant & $past(port_grant)) == '0));

   // R8: an enabled done pulse raises the interrupt line
   a_r8_irq_rises: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(ch_done_set & ch_irqen_vec)) && !bus_we) |=> irq_out);

   // R10: an address error halts the controller
   a_r10_err_halts: assert property (@(posedge clk) disable iff (!rst_n)
      (|ch_addr_err) |=> (glb_halt && glb_aerr && port_grant == '0));

   // R4: the gap between channel windows and global registers reads zero
   a_r4_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(bus_addr) >= (NUM_CH * 32) && int'(bus_addr) < 'h300)
      |-> (bus_rdata == '0));
endmodule

bind dma_ctl_hub dma_hub_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
   .bus_rdata(bus_rdata), .ch_req(ch_req), .ch_done_set(ch_done_set),
   .ch_addr_err(ch_addr_err), .port_grant(port_grant), .irq_out(irq_out),
   .ch_run_vec(ch_run_vec), .ch_irqen_vec(ch_irqen_vec),
   .glb_en(glb_en), .glb_halt(glb_halt), .glb_aerr(glb_aerr),
   .glb_mode(glb_mode)
);

// File: tb/tb_dma_ctl_hub.sv
`timescale 1ns/1ps
module tb_dma_ctl_hub;
   localparam int NCH = 6;
   localparam int AW  = 10;
   localparam int DW  = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_wmask = '0;
   logic [DW-1:0] bus_rdata;
   logic [NCH-1:0] ch_req = '0;
   logic [NCH-1:0] ch_done_set = '0;
   logic [NCH-1:0] ch_addr_err = '0;
   logic [NCH-1:0] port_grant;
   logic          irq_out;

   int n_chk = 0;
   int n_bad = 0;
   int last_g = NCH - 1;
   bit finished = 1'b0;

   // {request pattern, expected grant} in fixed-priority mode
   localparam logic [11:0] FX_TBL [8] = '{
      {6'b000000, 6'b000000}, {6'b000001, 6'b000001},
      {6'b111111, 6'b000001}, {6'b111110, 6'b000010},
      {6'b101000, 6'b001000}, {6'b110000, 6'b010000},
      {6'b100000, 6'b100000}, {6'b010100, 6'b000100}};

   always #10 clk = ~clk;

   dma_ctl_hub #(.NUM_CH(NCH), .ADDR_W(AW), .DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_wmask(bus_wmask), .bus_rdata(bus_rdata),
      .ch_req(ch_req), .ch_done_set(ch_done_set), .ch_addr_err(ch_addr_err),
      .port_grant(port_grant), .irq_out(irq_out));

   task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp,
                      input string what);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [DW-1:0] d, input logic [DW-1:0] m);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d; bus_wmask = m;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input int a, input logic [DW-1:0] exp, input string what);
      bus_addr = AW'(a);
      #1;
      chk(bus_rdata, exp, what);
   endtask

   function automatic logic [NCH-1:0] rr_pick(input int last, input logic [NCH-1:0] el);
      for (int k = 1; k <= NCH; k++)
         if (el[(last + k) % NCH]) return NCH'(1) << ((last + k) % NCH);
      return '0;
   endfunction

   function automatic int idx_of(input logic [NCH-1:0] g);
      for (int i = 0; i < NCH; i++) if (g[i]) return i;
      return -1;
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: reset state
      rd('h300, 32'h0, "R2 control after reset");
      rd('h304, 32'h0, "R8 summary after reset");
      chk(DW'(irq_out), 0, "R8 irq after reset");

      // R1: strided bank storage
      wr(3*32 + 'h00, 32'hA5A5_0003, '1);
      wr(5*32 + 'h18, 32'h1234_5678, '1);
      rd(3*32 + 'h00, 32'hA5A5_0003, "R1 ch3 source");
      rd('hB8, 32'h1234_5678, "R1 ch5 descriptor");
      rd('h00, 32'h0, "R1 ch0 source untouched");
      rd(2*32 + 'h14, 32'h0, "R1 ch2 command untouched");

      // R3 / R2: masked writes on the control word
      wr('h300, 32'h0000_030F, 32'h0000_0100);
      rd('h300, 32'h0000_0100, "R3 only masked bit changes");
      wr('h300, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      rd('h300, 32'h0000_030D, "R2 only defined bits kept");

      // R5: halt blocks grants
      for (int c = 0; c < NCH; c++) wr(c*32 + 'h10, 32'h1, 32'h1);
      @(negedge clk); ch_req = '1; #1;
      chk(DW'(port_grant), 0, "R5 halted gives no grant");
      @(negedge clk); ch_req = '0;
      wr('h300, 32'h0, 32'h1);
      @(negedge clk); ch_req = '1; #1;
      chk(DW'(port_grant), 0, "R5 disabled gives no grant");
      @(negedge clk); ch_req = '0;
      // start: enable set, halt cleared in one masked write, mode 0
      wr('h300, 32'h1, 32'h30D);
      rd('h300, 32'h1, "R3 start write");

      // R6: fixed-priority table
      foreach (FX_TBL[t]) begin
         @(negedge clk);
         ch_req = FX_TBL[t][11:6];
         #1;
         chk(DW'(port_grant), DW'(FX_TBL[t][5:0]), $sformatf("R6 fixed entry %0d", t));
         if (FX_TBL[t][5:0] != '0) last_g = idx_of(FX_TBL[t][5:0]);
      end
      @(negedge clk); ch_req = '0;

      // R7: round robin
      wr('h300, 32'h100, 32'h300);
      for (int s = 0; s < 11; s++) begin
         logic [NCH-1:0] rq, ex;
         rq = (s < 7) ? 6'b111111 : (s < 10) ? 6'b100001 : 6'b000010;
         @(negedge clk);
         ch_req = rq;
         #1;
         ex = rr_pick(last_g, rq);
         chk(DW'(port_grant), DW'(ex), $sformatf("R7 rotation step %0d", s));
         if (ex != '0) last_g = idx_of(ex);
      end
      @(negedge clk); ch_req = '0;

      // R5: per-channel run bit
      wr(1*32 + 'h10, 32'h0, 32'h1);
      @(negedge clk); ch_req = 6'b000010; #1;
      chk(DW'(port_grant), 0, "R5 stopped channel not granted");
      @(negedge clk); ch_req = 6'b000011; #1;
      chk(DW'(port_grant), 1, "R5 running channel granted");
      @(negedge clk); ch_req = '0;

      // R4: unmapped space
      wr('h1C, 32'hFFFF_FFFF, '1);
      rd('h1C, 32'h0, "R4 slot 0x1C reads zero");
      rd('h18, 32'h0, "R4 neighbour of 0x1C untouched");
      wr('hC0, 32'hFFFF_FFFF, '1);
      rd('h00, 32'h0, "R4 write past last channel ignored");
      rd('h200, 32'h0, "R4 gap reads zero");
      rd('h3F0, 32'h0, "R4 above globals reads zero");
      rd('h302, 32'h0, "R4 unaligned reads zero");

      // R8: completion and interrupt
      wr(2*32 + 'h14, 32'h2, 32'h2);
      @(negedge clk); ch_done_set = 6'b000100;
      @(negedge clk); ch_done_set = '0; #1;
      chk(DW'(irq_out), 1, "R8 irq after enabled done");
      rd('h304, 32'h4, "R8 summary bit 2");
      rd('h50, 32'h9, "R8 ch2 status done bit");
      @(negedge clk); ch_done_set = 6'b010000;
      @(negedge clk); ch_done_set = '0;
      rd('h304, 32'h4, "R8 masked channel stays out of summary");
      rd('h90, 32'h9, "R8 ch4 status done bit");

      // R9: clear done
      wr('h50, 32'h0, 32'h8);
      rd('h304, 32'h0, "R9 summary cleared");
      chk(DW'(irq_out), 0, "R9 irq dropped");

      // R8: done pulse beats same-cycle clear
      @(negedge clk);
      bus_we = 1'b1; bus_addr = AW'('h50); bus_wdata = '0; bus_wmask = 32'h8;
      ch_done_set = 6'b000100;
      @(negedge clk);
      bus_we = 1'b0; ch_done_set = '0;
      rd('h50, 32'h9, "R8 hardware set wins");
      chk(DW'(irq_out), 1, "R8 irq after collision");

      // R10: address error
      @(negedge clk); ch_addr_err = 6'b000001;
      @(negedge clk); ch_addr_err = '0;
      rd('h300, 32'h10D, "R10 global error and halt");
      rd('h10, 32'h11, "R10 ch0 status error bit");
      ch_req = 6'b000001; #1;
      chk(DW'(port_grant), 0, "R10 no grant after error");
      @(negedge clk); ch_req = '0;

      // R11: doorbell
      wr('h30C, 32'h15, 32'h3F);
      rd('h308, 32'h15, "R11 doorbell set");
      wr('h30C, 32'h02, 32'h3F);
      rd('h308, 32'h17, "R11 doorbell accumulates");
      wr('h308, 32'h05, 32'h3F);
      rd('h308, 32'h12, "R11 doorbell clear");
      wr('h30C, 32'hFFFF_FFC0, '1);
      rd('h308, 32'h12, "R11 high bits not stored");

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule